// File: doc/BRIEF.md
# Serial Avionics Word Receiver

This block takes the decoded three-level state of a return-to-zero avionics data line and turns it into 32-bit words for a host. The line receiver in front of it reports two logic levels, a "one" level and a "zero" level; both low means the line is null. A bit is taken each time the line enters a data level, so the exact bit period does not matter. A word timer counts whole null bit-times to find word boundaries, throws away malformed activity, and holds the receiver off until the line has been quiet for a while.

A word is accepted at the end of its trailing gap. It must have the expected length. When the source/destination check is on, its two-bit identifier field must also match a configured code. The accepted word is stored with its top bit replaced by a flag that reports the parity of the word as received. A data-ready flag is then raised.

The host picks one 16-bit half with a select input and strobes a read. Data-ready drops only after both halves have been read since the last word was stored. A self-test input switches the receiver from the line inputs to a loop-back pair that a neighbouring transmitter drives.

Top module: `a429_word_rx`

## Requirements
- R1: The line is one when lineOne=1 and lineZero=0, zero when lineZero=1 and lineOne=0, and null otherwise. A bit is taken on each clock where the line enters one or zero from any other state. The first bit of a word lands in bit 0 of the stored word, so it appears on rdData bit 0 when halfSel=0.
- R2: A null bit-time is HI_BIT_CLKS consecutive null clocks when lowRate=0, and HI_BIT_CLKS*LOW_RATE_DIV consecutive null clocks when lowRate=1.
- R3: Words whose bit period is anywhere from 90% to 110% of nominal are received without error.
- R4: A word in progress ends after NULL_RESET consecutive null bit-times (default 2). It is stored only if exactly 2*RD_WIDTH bits (default 32) were taken; a shorter word leaves data-ready and the stored word unchanged.
- R5: If a word reaches more than MAX_DATA_BITS bits (default 32) before a gap ends it, the word is discarded and the receiver is disabled.
- R6: After reset, after a word ends, and after a discard, no bit is taken until REARM_NULLS consecutive null bit-times (default 4) have passed. A word that starts earlier is ignored as a whole.
- R7: With sdiCheckEn=1, a word is stored only if its bits 9:8 equal sdiCode. With sdiCheckEn=0, the field is not checked.
- R8: Bits 30:0 of the stored word are the received bits. Bit 31 is 0 if the 32 received bits held an odd count of ones and 1 if they held an even count.
- R9: rdData always shows bits 15:0 of the stored word when halfSel=0 and bits 31:16 when halfSel=1. It changes only when halfSel changes or a new word is stored.
- R10: dataReady rises in the cycle after a word is stored. It falls only after readStb has been seen with halfSel=0 and with halfSel=1 since that word, in either order. Repeated reads of one half do not clear it.
- R11: A word completed while the previous one is unread replaces it. dataReady stays high, and read tracking starts over for the new word.
- R12: With selfTestEn=1, the receiver takes loopOne/loopZero as the line, and activity on lineOne/lineZero has no effect.
- R13: After reset, dataReady is 0 and both halves of the stored word read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| lineOne | input | 1 | Line receiver reports the one level |
| lineZero | input | 1 | Line receiver reports the zero level |
| loopOne | input | 1 | Loop-back one level for self-test |
| loopZero | input | 1 | Loop-back zero level for self-test |
| selfTestEn | input | 1 | Selects the loop-back pair instead of the line |
| lowRate | input | 1 | 0: high bit rate, 1: low bit rate |
| sdiCheckEn | input | 1 | Enables the identifier field match |
| sdiCode | input | 2 | Identifier value a word must carry |
| halfSel | input | 1 | 0: lower half, 1: upper half of stored word |
| readStb | input | 1 | One-cycle host read strobe for the selected half |
| rdData | output | RD_WIDTH | Selected half of the stored word |
| dataReady | output | 1 | A stored word is waiting to be read |

## Verification
A wrong bit count or a stuck enable state in the word timer shows at the ports within one word. The word is then dropped, so dataReady stays low, or bits are shifted, so both halves differ from the sent word. Near-misses around the length limit, the gap count and the re-arm count are sent on purpose to expose off-by-one errors. A fault in the read tracking shows within a single host read: dataReady falls after one half, or stays high after both. A fault in the parity flag or the identifier match shows in bit 31 of the upper half, or as a missing data-ready, on the first word that exercises it.

// File: rtl/a429_rx_pkg.sv
package a429_rx_pkg;

  typedef enum logic [1:0] {
    LINE_NULL = 2'd0,
    LINE_ZERO = 2'd1,
    LINE_ONE  = 2'd2
  } lineSym_e;

  typedef struct packed {
    logic shiftEn;   // take one bit into the shift register
    logic shiftBit;  // value of that bit
    logic latchEn;   // move the assembled word into the host latch
  } rxStrobe_t;

endpackage

// File: rtl/a429_rx_ctrl.sv
module a429_rx_ctrl
  import a429_rx_pkg::*;
#(
  parameter int HI_BIT_CLKS   = 1000,
  parameter int LOW_RATE_DIV  = 8,
  parameter int WORD_BITS     = 32,
  parameter int NULL_RESET    = 2,
  parameter int REARM_NULLS   = 4,
  parameter int MAX_DATA_BITS = 32
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      symOne,
  input  logic      symZero,
  input  logic      lowRate,
  input  logic      sdiOk,
  output rxStrobe_t stb
);

  localparam int LO_BIT_CLKS = HI_BIT_CLKS * LOW_RATE_DIV;
  localparam int GAP_W       = $clog2(LO_BIT_CLKS + 1);
  localparam int BIT_CNT_W   = $clog2(MAX_DATA_BITS + 2);
  localparam int RUN_MAX     = (NULL_RESET > REARM_NULLS) ? NULL_RESET : REARM_NULLS;
  localparam int RUN_W       = $clog2(RUN_MAX + 1);

  lineSym_e             curSym, prevSym;
  logic [GAP_W-1:0]     gapCnt, bitLimit;
  logic [BIT_CNT_W-1:0] bitCnt, bitCntNxt;
  logic [RUN_W-1:0]     nullRun, nullRunNxt;
  logic                 rxOn, rxOnNxt;
  logic                 dataEdge, nullTick;

  always_comb begin
    unique case ({symOne, symZero})
      2'b10:   curSym = LINE_ONE;
      2'b01:   curSym = LINE_ZERO;
      default: curSym = LINE_NULL;
    endcase
  end

  assign bitLimit = lowRate ? GAP_W'(LO_BIT_CLKS - 1) : GAP_W'(HI_BIT_CLKS - 1);
  assign dataEdge = (curSym != LINE_NULL) && (curSym != prevSym);
  assign nullTick = (curSym == LINE_NULL) && (gapCnt >= bitLimit);

  // word timer: enable, bit count and null-run decisions
  always_comb begin
    rxOnNxt    = rxOn;
    bitCntNxt  = bitCnt;
    nullRunNxt = nullRun;
    stb        = '0;
    if (curSym != LINE_NULL) nullRunNxt = '0;
    if (!rxOn) begin
      if (nullTick) begin
        if (nullRun == RUN_W'(REARM_NULLS - 1)) begin
          rxOnNxt    = 1'b1;
          nullRunNxt = '0;
        end else begin
          nullRunNxt = nullRun + RUN_W'(1);
        end
      end
    end else if (dataEdge) begin
      if (bitCnt == BIT_CNT_W'(MAX_DATA_BITS)) begin
        rxOnNxt   = 1'b0;
        bitCntNxt = '0;
      end else begin
        stb.shiftEn  = 1'b1;
        stb.shiftBit = (curSym == LINE_ONE);
        bitCntNxt    = bitCnt + BIT_CNT_W'(1);
      end
    end else if (nullTick && (bitCnt != '0)) begin
      if (nullRun == RUN_W'(NULL_RESET - 1)) begin
        stb.latchEn = (bitCnt == BIT_CNT_W'(WORD_BITS)) && sdiOk;
        rxOnNxt     = 1'b0;
        bitCntNxt   = '0;
        nullRunNxt  = '0;
      end else begin
        nullRunNxt = nullRun + RUN_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevSym <= LINE_NULL;
      gapCnt  <= '0;
      bitCnt  <= '0;
      nullRun <= '0;
      rxOn    <= 1'b0;
    end else begin
      prevSym <= curSym;
      if (curSym != LINE_NULL || nullTick) gapCnt <= '0;
      else                                 gapCnt <= gapCnt + GAP_W'(1);
      bitCnt  <= bitCntNxt;
      nullRun <= nullRunNxt;
      rxOn    <= rxOnNxt;
    end
  end

endmodule

// File: rtl/a429_rx_dpath.sv
module a429_rx_dpath
  import a429_rx_pkg::*;
#(
  parameter int RD_WIDTH = 16,
  parameter int SDI_LSB  = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  rxStrobe_t           stb,
  input  logic                sdiCheckEn,
  input  logic [1:0]          sdiCode,
  input  logic                halfSel,
  input  logic                readStb,
  output logic                sdiOk,
  output logic [RD_WIDTH-1:0] rdData,
  output logic                dataReady
);

  localparam int NUM_HALVES = 2;
  localparam int WORD_BITS  = NUM_HALVES * RD_WIDTH;

  logic [WORD_BITS-1:0]                 shiftReg;
  logic [NUM_HALVES-1:0][RD_WIDTH-1:0]  rxHalf;
  logic [NUM_HALVES-1:0]                gotHalf, readNow;
  logic                                 parityFlag;

  assign sdiOk      = !sdiCheckEn || (shiftReg[SDI_LSB +: 2] == sdiCode);
  assign parityFlag = ~^shiftReg;
  assign rdData     = rxHalf[halfSel];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      rxHalf   <= '0;
    end else begin
      if (stb.shiftEn) shiftReg <= {stb.shiftBit, shiftReg[WORD_BITS-1:1]};
      if (stb.latchEn) rxHalf   <= {parityFlag, shiftReg[WORD_BITS-2:0]};
    end
  end

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    assign readNow[h] = readStb && (halfSel == 1'(h));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            gotHalf[h] <= 1'b0;
      else if (stb.latchEn) gotHalf[h] <= 1'b0;
      else if (readNow[h])  gotHalf[h] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         dataReady <= 1'b0;
    else if (stb.latchEn)              dataReady <= 1'b1;
    else if (&(gotHalf | readNow))     dataReady <= 1'b0;
  end

endmodule

// File: rtl/a429_word_rx.sv
module a429_word_rx
  import a429_rx_pkg::*;
#(
  parameter int RD_WIDTH      = 16,
  parameter int HI_BIT_CLKS   = 1000,
  parameter int LOW_RATE_DIV  = 8,
  parameter int NULL_RESET    = 2,
  parameter int REARM_NULLS   = 4,
  parameter int MAX_DATA_BITS = 32,
  parameter int SDI_LSB       = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                lineOne,
  input  logic                lineZero,
  input  logic                loopOne,
  input  logic                loopZero,
  input  logic                selfTestEn,
  input  logic                lowRate,
  input  logic                sdiCheckEn,
  input  logic [1:0]          sdiCode,
  input  logic                halfSel,
  input  logic                readStb,
  output logic [RD_WIDTH-1:0] rdData,
  output logic                dataReady
);

  localparam int WORD_BITS = 2 * RD_WIDTH;

  rxStrobe_t rxStb;
  logic      sdiOk;
  logic      effOne, effZero;

  assign effOne  = selfTestEn ? loopOne  : lineOne;
  assign effZero = selfTestEn ? loopZero : lineZero;

  a429_rx_ctrl #(
    .HI_BIT_CLKS  (HI_BIT_CLKS),
    .LOW_RATE_DIV (LOW_RATE_DIV),
    .WORD_BITS    (WORD_BITS),
    .NULL_RESET   (NULL_RESET),
    .REARM_NULLS  (REARM_NULLS),
    .MAX_DATA_BITS(MAX_DATA_BITS)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .symOne (effOne),
    .symZero(effZero),
    .lowRate(lowRate),
    .sdiOk  (sdiOk),
    .stb    (rxStb)
  );

  a429_rx_dpath #(
    .RD_WIDTH(RD_WIDTH),
    .SDI_LSB (SDI_LSB)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (rxStb),
    .sdiCheckEn(sdiCheckEn),
    .sdiCode   (sdiCode),
    .halfSel   (halfSel),
    .readStb   (readStb),
    .sdiOk     (sdiOk),
    .rdData    (rdData),
    .dataReady (dataReady)
  );

endmodule

// File: rtl/a429_rx_chk.sv
module a429_rx_chk
  import a429_rx_pkg::*;
#(
  parameter int RD_WIDTH = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic                lineOne,
  input logic                lineZero,
  input logic                loopOne,
  input logic                loopZero,
  input logic                selfTestEn,
  input logic                halfSel,
  input logic                readStb,
  input logic [RD_WIDTH-1:0] rdData,
  input logic                dataReady,
  input rxStrobe_t           rxStb
);

  logic chkOne, chkZero;
  assign chkOne  = selfTestEn ? loopOne  : lineOne;
  assign chkZero = selfTestEn ? loopZero : lineZero;

  // R1 R12
  shift_on_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxStb.shiftEn |-> ((chkOne ^ chkZero) && (rxStb.shiftBit == chkOne)));

  // R10
  ready_after_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxStb.latchEn |=> dataReady);

  // R10
  ready_only_on_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!dataReady && !rxStb.latchEn) |=> !dataReady);

  // R10
  ready_holds_unread_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dataReady && !readStb) |=> dataReady);

  // R9
  rddata_steady_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rxStb.latchEn |=> (!$stable(halfSel) || $stable(rdData)));

endmodule

bind a429_word_rx a429_rx_chk #(.RD_WIDTH(RD_WIDTH)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .lineOne   (lineOne),
  .lineZero  (lineZero),
  .loopOne   (loopOne),
  .loopZero  (loopZero),
  .selfTestEn(selfTestEn),
  .halfSel   (halfSel),
  .readStb   (readStb),
  .rdData    (rdData),
  .dataReady (dataReady),
  .rxStb     (rxStb)
);

// File: tb/a429_word_rx_bench.sv
module a429_word_rx_bench;

  localparam int RDW = 16;
  localparam int HIB = 20;
  localparam int DIV = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN = 1'b0;
  logic lineOne = 1'b0, lineZero = 1'b0, loopOne = 1'b0, loopZero = 1'b0;
  logic selfTestEn = 1'b0, lowRate = 1'b0, sdiCheckEn = 1'b0;
  logic [1:0] sdiCode = 2'd0;
  logic halfSel = 1'b0, readStb = 1'b0;
  logic [RDW-1:0] rdData;
  logic dataReady;

  a429_word_rx #(.RD_WIDTH(RDW), .HI_BIT_CLKS(HIB), .LOW_RATE_DIV(DIV)) u_a429_word_rx (
    .clk(clk), .rstN(rstN), .lineOne(lineOne), .lineZero(lineZero),
    .loopOne(loopOne), .loopZero(loopZero), .selfTestEn(selfTestEn),
    .lowRate(lowRate), .sdiCheckEn(sdiCheckEn), .sdiCode(sdiCode),
    .halfSel(halfSel), .readStb(readStb), .rdData(rdData), .dataReady(dataReady)
  );

  int  nCmp = 0;
  int  nBad = 0;
  bit  txLoop = 1'b0;

  function automatic logic [31:0] stored(input logic [31:0] w);
    return {~^w, w[30:0]};
  endfunction

  task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic putSym(input logic one, input logic zero);
    if (txLoop) begin loopOne = one; loopZero = zero; end
    else        begin lineOne = one; lineZero = zero; end
  endtask

  task automatic sendBit(input logic b, input int per);
    putSym(b, ~b);
    repeat (per / 2) @(negedge clk);
    putSym(1'b0, 1'b0);
    repeat (per - per / 2) @(negedge clk);
  endtask

  task automatic sendWord(input logic [31:0] w, input int nb, input int per);
    for (int i = 0; i < nb; i++) sendBit(w[i % 32], per);
  endtask

  task automatic idle(input int nBits, input int per);
    putSym(1'b0, 1'b0);
    repeat (nBits * per) @(negedge clk);
  endtask

  task automatic peek(input logic sel, output logic [15:0] d);
    halfSel = sel;
    #1 d = rdData;
  endtask

  task automatic readHalf(input logic sel, output logic [15:0] d);
    @(negedge clk);
    halfSel = sel;
    #1 d = rdData;
    readStb = 1'b1;
    @(negedge clk);
    readStb = 1'b0;
    #1;
  endtask

  task automatic checkReady(input string tag, input logic exp);
    #1 cmp(tag, {31'd0, dataReady}, {31'd0, exp});
  endtask

  // send, wait out the gap, then read both halves and check everything
  task automatic fullWord(input string tag, input logic [31:0] w, input int per, input logic hiFirst);
    logic [15:0] a, b;
    logic [31:0] e;
    e = stored(w);
    sendWord(w, 32, per);
    idle(8, per);
    checkReady({tag, " R10 ready"}, 1'b1);
    readHalf(hiFirst, a);
    checkReady({tag, " R10 half read keeps ready"}, 1'b1);
    readHalf(~hiFirst, b);
    checkReady({tag, " R10 both read clears"}, 1'b0);
    if (hiFirst) begin
      cmp({tag, " R1 R9 low half"}, {16'd0, b}, {16'd0, e[15:0]});
      cmp({tag, " R8 R9 high half"}, {16'd0, a}, {16'd0, e[31:16]});
    end else begin
      cmp({tag, " R1 R9 low half"}, {16'd0, a}, {16'd0, e[15:0]});
      cmp({tag, " R8 R9 high half"}, {16'd0, b}, {16'd0, e[31:16]});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    logic [15:0] d0, d1;
    logic [31:0] w, wa, wb;

    repeat (4) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R13 reset state
    cmp("R13 ready after reset", {31'd0, dataReady}, 32'd0);
    peek(1'b0, d0);
    peek(1'b1, d1);
    cmp("R13 stored word after reset", {d1, d0}, 32'd0);

    // R6: a word right after reset arrives before re-arm and is dropped
    idle(1, HIB);
    sendWord(32'hA5C3_0F96, 32, HIB);
    idle(8, HIB);
    checkReady("R6 early word ignored", 1'b0);

    // R1 R3 R7 R8 R9 R10: sweep of patterns, periods 90/100/110 %, identifier checking
    for (int i = 0; i < 16; i++) begin
      int per;
      per        = 18 + 2 * (i % 3);
      sdiCheckEn = i[3];
      sdiCode    = 2'(i);
      w = ((32'h2468_ACE1 ^ (32'(i) * 32'h9E37_79B1)) & ~32'h0000_0300) | (32'(i % 4) << 8);
      fullWord("R3 sweep", w, per, i[2]);
    end
    sdiCheckEn = 1'b0;

    // R8 parity flag corners: even count gives 1, odd count gives 0 over the received bit 31
    fullWord("R8 even zeros", 32'h0000_0000, HIB, 1'b0);
    fullWord("R8 odd top bit", 32'h8000_0000, HIB, 1'b1);

    // R10 repeated read of one half does not clear
    sendWord(32'h1234_5678, 32, HIB);
    idle(8, HIB);
    readHalf(1'b0, d0);
    readHalf(1'b0, d0);
    checkReady("R10 same half twice", 1'b1);
    readHalf(1'b1, d1);
    checkReady("R10 other half clears", 1'b0);

    // R4 short word, R5 long word
    sendWord(32'h0F0F_1234, 31, HIB);
    idle(8, HIB);
    checkReady("R4 31-bit word dropped", 1'b0);
    sendWord(32'h0F0F_1234, 33, HIB);
    idle(8, HIB);
    checkReady("R5 33-bit word dropped", 1'b0);
    fullWord("R5 recovery", 32'h55AA_33CC, HIB, 1'b0);

    // R7 identifier mismatch then check disabled
    sdiCheckEn = 1'b1;
    sdiCode    = 2'd2;
    w = 32'h7700_0100;
    sendWord(w, 32, HIB);
    idle(8, HIB);
    checkReady("R7 identifier mismatch dropped", 1'b0);
    sdiCheckEn = 1'b0;
    fullWord("R7 unchecked accepted", w, HIB, 1'b1);

    // R11 overwrite with tracking restart
    wa = 32'h0123_4567;
    wb = 32'hFEDC_BA98;
    sendWord(wa, 32, HIB);
    idle(8, HIB);
    readHalf(1'b0, d0);
    sendWord(wb, 32, HIB);
    idle(8, HIB);
    checkReady("R11 ready after overwrite", 1'b1);
    readHalf(1'b1, d1);
    cmp("R11 new high half", {16'd0, d1}, {16'd0, stored(wb) >> 16});
    checkReady("R11 earlier read not counted", 1'b1);
    readHalf(1'b0, d0);
    cmp("R11 new low half", {16'd0, d0}, {16'd0, stored(wb) & 32'hFFFF});
    checkReady("R11 cleared", 1'b0);

    // R6 gap too short before next word
    wa = 32'h3C3C_A0A0;
    sendWord(wa, 32, HIB);
    idle(3, HIB);
    sendWord(32'hFFFF_0000, 32, HIB);
    idle(8, HIB);
    peek(1'b0, d0);
    peek(1'b1, d1);
    cmp("R6 word inside re-arm window ignored", {d1, d0}, stored(wa));
    readHalf(1'b0, d0);
    readHalf(1'b1, d1);

    // R2 null bit-time length follows the rate setting
    sendWord(32'h0BAD_F00D, 32, HIB);
    idle(3, HIB);
    checkReady("R2 high rate ends after two null bits", 1'b1);
    readHalf(1'b0, d0);
    readHalf(1'b1, d1);
    idle(8, HIB);
    lowRate = 1'b1;
    idle(8, HIB * DIV);
    w = 32'hC0DE_1357;
    sendWord(w, 32, HIB * DIV);
    idle(4, HIB);
    checkReady("R2 low rate gap not yet two null bits", 1'b0);
    idle(8, HIB * DIV);
    checkReady("R2 low rate ready", 1'b1);
    peek(1'b0, d0);
    peek(1'b1, d1);
    cmp("R2 low rate word", {d1, d0}, stored(w));
    readHalf(1'b0, d0);
    readHalf(1'b1, d1);
    lowRate = 1'b0;
    idle(8, HIB * DIV);

    // R12 self-test loop path used, line ignored
    selfTestEn = 1'b1;
    idle(6, HIB);
    txLoop = 1'b1;
    fullWord("R12 loop path", 32'h6B2F_90E4, HIB, 1'b0);
    txLoop = 1'b0;
    sendWord(32'h1111_2222, 32, HIB);
    idle(8, HIB);
    checkReady("R12 line ignored in self-test", 1'b0);
    peek(1'b0, d0);
    peek(1'b1, d1);
    cmp("R12 stored word untouched", {d1, d0}, stored(32'h6B2F_90E4));
    selfTestEn = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule